// File: doc/BRIEF.md
# Video Memory Access Slot Arbiter

This block decides which of two clients may use each free access slot on a video memory bus: a processor port and a drawing-engine port. The bus is shared with display fetching and refresh, so client accesses may start only at fixed cycles of the horizontal line. The positions of those cycles depend on a three-way operating mode: display blanked, display without sprites, or display with sprites. A free-running line position counter indexes the slot table.

Each client has a single-entry request holder for direction, address and write data. Sixteen cycles before every slot the arbiter commits that slot. The processor wins over the drawing engine, and the slot stays empty if neither has a pending request. When the slot arrives the committed holder is emptied and a six-cycle single access drives the memory side. Read data returns to the requester with a one-cycle valid pulse. A newer processor request replaces an unserved one and is counted as dropped. The drawing engine is instead held off with a stall flag while its holder is occupied, so none of its requests is lost.

Top module: `vsa_slot_arbiter`

## Requirements
- R1: During and after reset, before any request, line_pos is 0, cmd_stall is 0, mem_act is 0, cpu_rvalid and cmd_rvalid are 0 and cpu_drop_cnt is 0.
- R2: line_pos advances by one every clock from 0 up to 1367 and then returns to 0.
- R3: With mode 2'b00 (display blanked), slots lie at every line position that is a multiple of 8 and below 1232, which gives 154 slots.
- R4: With mode 2'b01 (display on, sprites off), slots lie at positions 4 + 15*k for k = 0 to 87, which gives 88 slots.
- R5: With mode 2'b10 or 2'b11 (display and sprites on), there are 31 slots, at positions 28, 92, 162, 170, 188, 220, 252, 316, 348, 380, 444, 476, 508, 572, 604, 636, 700, 732, 764, 828, 860, 892, 956, 988, 1020, 1084, 1116, 1148, 1212, 1264 and 1330.
- R6: A slot S is committed at the clock edge where line_pos equals S-16 (modulo 1368). The committed source is the processor if its holder is pending and not yet committed. Otherwise it is the drawing engine under the same condition. Otherwise the slot stays empty. A used slot shows mem_act high while line_pos runs from S+1 to S+6.
- R7: A request captured at the commit edge of a slot, or later, is not served in that slot, even if the slot stays empty.
- R8: A processor request arriving while an earlier processor request is still pending replaces it, and cpu_drop_cnt increases by one. The access then carries the newest address, direction and data, even if the replacement came after the commit.
- R9: cmd_stall rises in the cycle after a drawing-engine request is captured. It stays high until the edge that starts the serving access, and is low from the next cycle on.
- R10: An access holds mem_act, mem_we, mem_addr and mem_wdata steady for exactly 6 cycles. mem_we high means write.
- R11: For a read served at slot S, rd_data carries the memory byte at line_pos S+7. In that same cycle exactly one of cpu_rvalid or cmd_rvalid pulses high for one cycle, matching the source.
- R12: A holder is emptied at the edge of its serving slot. A processor request captured on that same edge becomes a new pending request, with no drop counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 blanked, 01 sprites off, 1x sprites on |
| cpu_req | input | 1 | Processor request strobe |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | 17 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cmd_req | input | 1 | Drawing-engine request strobe, valid only while cmd_stall is low |
| cmd_we | input | 1 | Drawing-engine write (1) or read (0) |
| cmd_addr | input | 17 | Drawing-engine byte address |
| cmd_wdata | input | 8 | Drawing-engine write data |
| cmd_stall | output | 1 | Drawing-engine holder occupied |
| mem_act | output | 1 | Access in progress |
| mem_we | output | 1 | Access direction |
| mem_addr | output | 17 | Access address |
| mem_wdata | output | 8 | Access write data |
| mem_rdata | input | 8 | Memory read data for mem_addr |
| rd_data | output | 8 | Returned read byte |
| cpu_rvalid | output | 1 | Read return pulse for the processor |
| cmd_rvalid | output | 1 | Read return pulse for the drawing engine |
| cpu_drop_cnt | output | 16 | Count of replaced processor requests |
| line_pos | output | 11 | Current line position |

## Verification
The bench targets requests that land exactly on a commit edge. A design that sampled the live strobe there would serve them a slot early. It also targets a processor replacement between commit and slot, which exposes a design that latched the contents at commit time and would write the stale address. A request placed on the serving edge itself checks that the new entry survives and no drop is counted; a wrong clear order would lose it or count it. Slots near the line end, committed on the previous line, catch lookahead arithmetic without modulo wrap, and back-to-back slots eight cycles apart catch a single commit register that lets the second commit overwrite the first.

// File: rtl/vsa_pkg.sv
package vsa_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_CMD  = 2'd2
  } src_e;

  localparam int unsigned SPR_SLOT_N = 31;
  localparam int unsigned SPR_SLOTS [SPR_SLOT_N] = '{
    28, 92, 162, 170, 188, 220, 252, 316, 348, 380, 444,
    476, 508, 572, 604, 636, 700, 732, 764, 828, 860, 892,
    956, 988, 1020, 1084, 1116, 1148, 1212, 1264, 1330
  };

  // Slot membership of a line position for a given operating mode.
  function automatic logic is_slot(input logic [1:0] m, input int unsigned p);
    logic hit;
    hit = 1'b0;
    case (m)
      2'b00:   hit = (p < 1232) && (p % 8 == 0);
      2'b01:   hit = (p >= 4) && (p <= 1309) && ((p - 4) % 15 == 0);
      default: begin
        for (int i = 0; i < int'(SPR_SLOT_N); i++)
          if (SPR_SLOTS[i] == p) hit = 1'b1;
      end
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/vsa_line_timer.sv
module vsa_line_timer #(
  parameter int LINE_LEN  = 1368,
  parameter int LOOKAHEAD = 16,
  localparam int PW = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  output logic [PW-1:0] pos,
  output logic          commit_hit
);
  logic [PW-1:0] pos_q, pos_n, ahead;
  logic [PW:0]   sum;

  always_comb begin
    pos_n = (pos_q == PW'(LINE_LEN - 1)) ? '0 : pos_q + 1'b1;
    sum   = {1'b0, pos_q} + (PW+1)'(LOOKAHEAD);
    ahead = (sum >= (PW+1)'(LINE_LEN)) ? PW'(sum - (PW+1)'(LINE_LEN)) : PW'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_n;
  end

  assign pos        = pos_q;
  assign commit_hit = vsa_pkg::is_slot(mode, int'(ahead));
endmodule

// File: rtl/vsa_req_buf.sv
module vsa_req_buf #(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter bit OVERWRITE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          serve,
  output logic          valid,
  output logic          q_we,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_wdata,
  output logic          dropped
);
  logic accept, valid_q, valid_n;
  logic we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  generate
    if (OVERWRITE) begin : g_replace
      assign accept  = req;
      assign dropped = req && valid_q && !serve;
    end else begin : g_hold
      assign accept  = req && !valid_q;
      assign dropped = 1'b0;
    end
  endgenerate

  always_comb begin
    valid_n = valid_q;
    if (serve)  valid_n = 1'b0;
    if (accept) valid_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      valid_q <= valid_n;
      if (accept) begin
        we_q    <= we;
        addr_q  <= addr;
        wdata_q <= wdata;
      end
    end
  end

  assign valid   = valid_q;
  assign q_we    = we_q;
  assign q_addr  = addr_q;
  assign q_wdata = wdata_q;
endmodule

// File: rtl/vsa_access.sv
module vsa_access #(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int ACC_LEN = 6,
  localparam int CW = $clog2(ACC_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  vsa_pkg::src_e start_src,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          mem_act,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] rd_data,
  output logic          cpu_rvalid,
  output logic          cmd_rvalid
);
  import vsa_pkg::*;

  logic [CW-1:0] cnt_q, cnt_n;
  src_e          src_q;
  logic          we_q, last, rd_done;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rd_q;
  logic          cpu_v_q, cmd_v_q;

  always_comb begin
    last    = (cnt_q == CW'(1));
    rd_done = last && !we_q;
    cnt_n   = cnt_q;
    if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
    if (start)       cnt_n = CW'(ACC_LEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      src_q   <= SRC_NONE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
      cpu_v_q <= 1'b0;
      cmd_v_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      cpu_v_q <= rd_done && (src_q == SRC_CPU);
      cmd_v_q <= rd_done && (src_q == SRC_CMD);
      if (start) begin
        src_q   <= start_src;
        we_q    <= we;
        addr_q  <= addr;
        wdata_q <= wdata;
      end
      if (rd_done) rd_q <= mem_rdata;
    end
  end

  assign mem_act    = (cnt_q != '0);
  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign rd_data    = rd_q;
  assign cpu_rvalid = cpu_v_q;
  assign cmd_rvalid = cmd_v_q;
endmodule

// File: rtl/vsa_slot_arbiter.sv
module vsa_slot_arbiter #(
  parameter int LINE_LEN  = 1368,
  parameter int LOOKAHEAD = 16,
  parameter int ACC_LEN   = 6,
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int DROP_W    = 16,
  localparam int PW = $clog2(LINE_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cmd_req,
  input  logic              cmd_we,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [DW-1:0]     cmd_wdata,
  output logic              cmd_stall,
  output logic              mem_act,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic [DW-1:0]     rd_data,
  output logic              cpu_rvalid,
  output logic              cmd_rvalid,
  output logic [DROP_W-1:0] cpu_drop_cnt,
  output logic [PW-1:0]     line_pos
);
  import vsa_pkg::*;

  logic          commit_hit;
  logic          cpu_valid, cmd_valid, cpu_drop;
  logic          cpu_q_we, cmd_q_we;
  logic [AW-1:0] cpu_q_addr, cmd_q_addr;
  logic [DW-1:0] cpu_q_wdata, cmd_q_wdata;
  logic          cpu_resv_q, cpu_resv_n, cmd_resv_q, cmd_resv_n;
  logic          serve_cpu, serve_cmd;
  src_e          grant, slot_src;
  src_e          pipe_q [LOOKAHEAD];
  src_e          pipe_n [LOOKAHEAD];
  logic [DROP_W-1:0] drop_q, drop_n;
  logic          acc_we;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata;

  vsa_line_timer #(.LINE_LEN(LINE_LEN), .LOOKAHEAD(LOOKAHEAD)) timer_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pos(line_pos), .commit_hit(commit_hit)
  );

  vsa_req_buf #(.AW(AW), .DW(DW), .OVERWRITE(1'b1)) cpu_buf_i (
    .clk(clk), .rst_n(rst_n), .req(cpu_req), .we(cpu_we), .addr(cpu_addr),
    .wdata(cpu_wdata), .serve(serve_cpu), .valid(cpu_valid), .q_we(cpu_q_we),
    .q_addr(cpu_q_addr), .q_wdata(cpu_q_wdata), .dropped(cpu_drop)
  );

  logic cmd_drop_unused;
  vsa_req_buf #(.AW(AW), .DW(DW), .OVERWRITE(1'b0)) cmd_buf_i (
    .clk(clk), .rst_n(rst_n), .req(cmd_req), .we(cmd_we), .addr(cmd_addr),
    .wdata(cmd_wdata), .serve(serve_cmd), .valid(cmd_valid), .q_we(cmd_q_we),
    .q_addr(cmd_q_addr), .q_wdata(cmd_q_wdata), .dropped(cmd_drop_unused)
  );

  // Commit decision and delay line that carries it to the slot start.
  always_comb begin
    grant = SRC_NONE;
    if (commit_hit) begin
      if (cpu_valid && !cpu_resv_q)      grant = SRC_CPU;
      else if (cmd_valid && !cmd_resv_q) grant = SRC_CMD;
    end
    pipe_n[0] = grant;
    for (int i = 1; i < LOOKAHEAD; i++) pipe_n[i] = pipe_q[i-1];
    slot_src   = pipe_q[LOOKAHEAD-1];
    serve_cpu  = (slot_src == SRC_CPU);
    serve_cmd  = (slot_src == SRC_CMD);
    cpu_resv_n = (cpu_resv_q && !serve_cpu) || (grant == SRC_CPU);
    cmd_resv_n = (cmd_resv_q && !serve_cmd) || (grant == SRC_CMD);
    drop_n     = cpu_drop ? drop_q + 1'b1 : drop_q;
    acc_we     = serve_cpu ? cpu_q_we    : cmd_q_we;
    acc_addr   = serve_cpu ? cpu_q_addr  : cmd_q_addr;
    acc_wdata  = serve_cpu ? cpu_q_wdata : cmd_q_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LOOKAHEAD; i++) pipe_q[i] <= SRC_NONE;
      cpu_resv_q <= 1'b0;
      cmd_resv_q <= 1'b0;
      drop_q     <= '0;
    end else begin
      for (int i = 0; i < LOOKAHEAD; i++) pipe_q[i] <= pipe_n[i];
      cpu_resv_q <= cpu_resv_n;
      cmd_resv_q <= cmd_resv_n;
      drop_q     <= drop_n;
    end
  end

  vsa_access #(.AW(AW), .DW(DW), .ACC_LEN(ACC_LEN)) access_i (
    .clk(clk), .rst_n(rst_n), .start(serve_cpu || serve_cmd), .start_src(slot_src),
    .we(acc_we), .addr(acc_addr), .wdata(acc_wdata),
    .mem_act(mem_act), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rd_data(rd_data),
    .cpu_rvalid(cpu_rvalid), .cmd_rvalid(cmd_rvalid)
  );

  assign cmd_stall    = cmd_valid;
  assign cpu_drop_cnt = drop_q;
endmodule

// File: rtl/vsa_checker.sv
module vsa_checker #(
  parameter int LINE_LEN = 1368,
  parameter int ACC_LEN  = 6,
  parameter int DROP_W   = 16,
  localparam int PW = $clog2(LINE_LEN),
  localparam int CW = $clog2(ACC_LEN + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_req,
  input logic              cmd_stall,
  input logic              mem_act,
  input logic              cpu_rvalid,
  input logic              cmd_rvalid,
  input logic [DROP_W-1:0] cpu_drop_cnt,
  input logic [PW-1:0]     line_pos
);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (mem_act) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pos == PW'(LINE_LEN - 1)) |=> (line_pos == '0));

  p_acc_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_act) |-> (run_q == CW'(ACC_LEN)));

  p_acc_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_act |-> (run_q < CW'(ACC_LEN)));

  p_stall_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_stall) |-> $past(cmd_req));

  p_stall_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_stall) |-> $rose(mem_act));

  p_rd_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rvalid || cmd_rvalid) |-> $fell(mem_act));

  p_rd_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rvalid && cmd_rvalid));

  p_cpu_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |=> !cpu_rvalid);

  p_cmd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rvalid |=> !cmd_rvalid);

  p_drop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_drop_cnt != $past(cpu_drop_cnt)) |-> (cpu_drop_cnt == DROP_W'($past(cpu_drop_cnt) + 1'b1)));
endmodule

bind vsa_slot_arbiter vsa_checker #(
  .LINE_LEN(LINE_LEN), .ACC_LEN(ACC_LEN), .DROP_W(DROP_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_stall(cmd_stall),
  .mem_act(mem_act), .cpu_rvalid(cpu_rvalid), .cmd_rvalid(cmd_rvalid),
  .cpu_drop_cnt(cpu_drop_cnt), .line_pos(line_pos)
);

// File: tb/vsa_slot_arbiter_tb.sv
module vsa_slot_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LLEN = 1368;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b10;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [16:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cmd_req = 1'b0, cmd_we = 1'b0;
  logic [16:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        cmd_stall, mem_act, mem_we, cpu_rvalid, cmd_rvalid;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, rd_data;
  logic [15:0] cpu_drop_cnt;
  logic [10:0] line_pos;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] bmem [0:131071];
  assign mem_rdata = bmem[mem_addr];
  always @(posedge clk) if (mem_act && mem_we) bmem[mem_addr] <= mem_wdata;

  vsa_slot_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cmd_req(cmd_req), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_stall(cmd_stall), .mem_act(mem_act), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rd_data(rd_data),
    .cpu_rvalid(cpu_rvalid), .cmd_rvalid(cmd_rvalid), .cpu_drop_cnt(cpu_drop_cnt),
    .line_pos(line_pos)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (time %0t)", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int unsigned spr_tab[$] = '{28, 92, 162, 170, 188, 220, 252, 316, 348, 380, 444,
    476, 508, 572, 604, 636, 700, 732, 764, 828, 860, 892, 956, 988, 1020, 1084,
    1116, 1148, 1212, 1264, 1330};

  function automatic bit ref_slot(input logic [1:0] m, input int p);
    if (m == 2'b00) return (p < 1232) && (p % 8 == 0);
    if (m == 2'b01) return (p >= 4) && (p <= 1309) && ((p - 4) % 15 == 0);
    foreach (spr_tab[i]) if (spr_tab[i] == p) return 1'b1;
    return 1'b0;
  endfunction

  int   m_pos, m_cyc, m_drop, m_left, m_src;
  bit   m_cpu_v, m_cpu_res, m_cmd_v, m_cmd_res;
  bit   m_cpu_we, m_cmd_we, m_we, m_cpu_rv, m_cmd_rv;
  logic [16:0] m_cpu_a, m_cmd_a, m_a;
  logic [7:0]  m_cpu_d, m_cmd_d, m_d, m_rd;
  int   q_time[$];
  int   q_src[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_cyc = 0; m_drop = 0; m_left = 0; m_src = 0;
      m_cpu_v = 0; m_cpu_res = 0; m_cmd_v = 0; m_cmd_res = 0;
      m_cpu_rv = 0; m_cmd_rv = 0; m_rd = '0; m_we = 0; m_a = '0; m_d = '0;
      q_time.delete(); q_src.delete();
    end else begin
      int  gsrc, ssrc;
      bit  old_cmd_v;
      old_cmd_v = m_cmd_v;
      m_cpu_rv = 0; m_cmd_rv = 0;
      if (m_left == 1 && !m_we) begin
        m_rd = bmem[m_a];
        if (m_src == 1) m_cpu_rv = 1; else m_cmd_rv = 1;
      end
      if (m_left > 0) m_left--;
      gsrc = 0;
      if (ref_slot(mode, (m_pos + 16) % LLEN)) begin
        if (m_cpu_v && !m_cpu_res) gsrc = 1;
        else if (m_cmd_v && !m_cmd_res) gsrc = 2;
      end
      ssrc = 0;
      if (q_time.size() > 0 && q_time[0] == m_cyc) begin
        ssrc = q_src.pop_front();
        void'(q_time.pop_front());
      end
      if (ssrc == 1) begin
        m_left = 6; m_src = 1; m_we = m_cpu_we; m_a = m_cpu_a; m_d = m_cpu_d;
        m_cpu_v = 0; m_cpu_res = 0;
      end else if (ssrc == 2) begin
        m_left = 6; m_src = 2; m_we = m_cmd_we; m_a = m_cmd_a; m_d = m_cmd_d;
        m_cmd_v = 0; m_cmd_res = 0;
      end
      if (gsrc != 0) begin
        q_time.push_back(m_cyc + 16);
        q_src.push_back(gsrc);
        if (gsrc == 1) m_cpu_res = 1; else m_cmd_res = 1;
      end
      if (cpu_req) begin
        if (m_cpu_v) m_drop++;
        m_cpu_v = 1; m_cpu_we = cpu_we; m_cpu_a = cpu_addr; m_cpu_d = cpu_wdata;
      end
      if (cmd_req && !old_cmd_v) begin
        m_cmd_v = 1; m_cmd_we = cmd_we; m_cmd_a = cmd_addr; m_cmd_d = cmd_wdata;
      end
      m_pos = (m_pos + 1) % LLEN;
      m_cyc++;
    end
  end

  bit live = 0;
  always @(negedge clk) begin
    if (rst_n && live) begin
      chk(line_pos == 11'(m_pos), "R2", "line_pos", line_pos, m_pos);
      chk(cmd_stall == m_cmd_v, "R9", "cmd_stall", cmd_stall, m_cmd_v);
      chk(mem_act == (m_left > 0), "R6", "mem_act", mem_act, m_left > 0);
      if (m_left > 0) begin
        chk(mem_addr == m_a, "R10", "mem_addr", mem_addr, m_a);
        chk(mem_we == m_we, "R10", "mem_we", mem_we, m_we);
        if (m_we) chk(mem_wdata == m_d, "R10", "mem_wdata", mem_wdata, m_d);
      end
      chk(cpu_rvalid == m_cpu_rv, "R11", "cpu_rvalid", cpu_rvalid, m_cpu_rv);
      chk(cmd_rvalid == m_cmd_rv, "R11", "cmd_rvalid", cmd_rvalid, m_cmd_rv);
      if (m_cpu_rv || m_cmd_rv) chk(rd_data == m_rd, "R11", "rd_data", rd_data, m_rd);
      chk(cpu_drop_cnt == 16'(m_drop), "R8", "cpu_drop_cnt", cpu_drop_cnt, m_drop);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic at_pos(input int p);
    @(negedge clk);
    while (int'(line_pos) != p) @(negedge clk);
  endtask

  task automatic cpu_issue(input bit we, input int a, input int d);
    cpu_req = 1; cpu_we = we; cpu_addr = 17'(a); cpu_wdata = 8'(d);
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int d0;
    for (int i = 0; i < 131072; i++) bmem[i] = 8'(i) ^ 8'h5a;
    repeat (4) @(negedge clk);
    chk(line_pos == 0 && !cmd_stall && !mem_act, "R1", "idle in reset", int'(mem_act), 0);
    chk(!cpu_rvalid && !cmd_rvalid && cpu_drop_cnt == 0, "R1", "outputs in reset", cpu_drop_cnt, 0);
    rst_n = 1;
    live = 1;
    @(negedge clk);
    chk(line_pos == 1 && !mem_act && !cmd_stall, "R1", "after release", line_pos, 1);

    // Line A (sprites on): write then late-arriving read.
    at_pos(100); cpu_issue(1, 'h123, 'ha5);
    at_pos(163); chk(mem_act && mem_we && mem_addr == 17'h123, "R5", "write at slot 162", mem_addr, 'h123);
    at_pos(300); cpu_issue(0, 'h123, 0);
    at_pos(317); chk(!mem_act, "R7", "request on commit edge of 316", mem_act, 0);
    at_pos(349); chk(mem_act && !mem_we && mem_addr == 17'h123, "R7", "read served at 348", mem_addr, 'h123);
    at_pos(355); chk(cpu_rvalid && rd_data == 8'ha5, "R11", "read return", rd_data, 'ha5);
    at_pos(1367); @(negedge clk);
    chk(line_pos == 0, "R2", "wrap", line_pos, 0);

    // Line B: late request, priority, overwrite, stall, serve-edge request.
    at_pos(150); cpu_issue(1, 'h200, 'h11);
    at_pos(163); chk(!mem_act, "R7", "slot 162 stays empty", mem_act, 0);
    at_pos(171); chk(mem_act && mem_addr == 17'h200, "R6", "served at 170", mem_addr, 'h200);
    at_pos(400);
    cmd_req = 1; cmd_we = 1; cmd_addr = 17'h301; cmd_wdata = 8'h22;
    cpu_issue(1, 'h300, 'h33);
    cmd_req = 0;
    chk(cmd_stall, "R9", "stall after capture", cmd_stall, 1);
    at_pos(445); chk(mem_addr == 17'h300, "R6", "processor wins 444", mem_addr, 'h300);
    at_pos(476); chk(cmd_stall, "R9", "stall held before slot", cmd_stall, 1);
    at_pos(477); chk(!cmd_stall && mem_addr == 17'h301, "R9", "engine served at 476", mem_addr, 'h301);
    d0 = int'(cpu_drop_cnt);
    at_pos(600); cpu_issue(1, 'h400, 'h44);
    at_pos(610); cpu_issue(1, 'h401, 'h45);
    chk(int'(cpu_drop_cnt) == d0 + 1, "R8", "drop counted", cpu_drop_cnt, d0 + 1);
    at_pos(637); chk(mem_addr == 17'h401 && mem_wdata == 8'h45, "R8", "newest served", mem_addr, 'h401);
    at_pos(700); cpu_issue(1, 'h500, 'h50);
    at_pos(720); cpu_issue(1, 'h501, 'h51);
    at_pos(733); chk(mem_addr == 17'h501, "R8", "replacement after commit", mem_addr, 'h501);
    d0 = int'(cpu_drop_cnt);
    at_pos(840); cpu_issue(1, 'h600, 'h60);
    at_pos(860); cpu_issue(1, 'h601, 'h61);
    chk(mem_addr == 17'h600 && int'(cpu_drop_cnt) == d0, "R12", "serve edge keeps old, no drop", cpu_drop_cnt, d0);
    at_pos(893); chk(mem_act && mem_addr == 17'h601, "R12", "new entry served at 892", mem_addr, 'h601);

    // Blanked mode.
    at_pos(LLEN - 1); mode = 2'b00;
    at_pos(20); cpu_issue(1, 'h700, 'h70);
    at_pos(33); chk(!mem_act, "R3", "slot 32 committed before request", mem_act, 0);
    at_pos(41); chk(mem_act && mem_addr == 17'h700, "R3", "slot 40", mem_addr, 'h700);
    at_pos(1240); cpu_issue(0, 'h700, 0);
    at_pos(1); chk(mem_act && mem_addr == 17'h700, "R3", "slot 0 committed on previous line", mem_addr, 'h700);
    at_pos(7); chk(cpu_rvalid && rd_data == 8'h70, "R11", "read in blanked mode", rd_data, 'h70);

    // Sprites-off mode.
    at_pos(LLEN - 1); mode = 2'b01;
    at_pos(10); cpu_issue(1, 'h710, 'h71);
    at_pos(20); chk(!mem_act, "R4", "slot 19 unused", mem_act, 0);
    at_pos(35); chk(mem_act && mem_addr == 17'h710, "R4", "slot 34", mem_addr, 'h710);
    at_pos(1300); cpu_issue(1, 'h711, 'h72);
    at_pos(1310); chk(!mem_act, "R4", "slot 1309 already committed", mem_act, 0);
    at_pos(5); chk(mem_act && mem_addr == 17'h711, "R4", "slot 4 of next line", mem_addr, 'h711);

    // Mixed traffic over several lines, all modes, compared every clock.
    for (int ln = 0; ln < 9; ln++) begin
      at_pos(LLEN - 1);
      mode = 2'(ln % 4);
      for (int c = 0; c < LLEN - 1; c++) begin
        if ($urandom_range(0, 39) == 0) begin
          cpu_req = 1; cpu_we = 1'($urandom_range(0, 1));
          cpu_addr = 17'($urandom_range(0, 63)); cpu_wdata = 8'($urandom);
        end else cpu_req = 0;
        if (!cmd_stall && $urandom_range(0, 19) == 0) begin
          cmd_req = 1; cmd_we = 1'($urandom_range(0, 1));
          cmd_addr = 17'($urandom_range(0, 63)); cmd_wdata = 8'($urandom);
        end else cmd_req = 0;
        @(negedge clk);
      end
      cpu_req = 0; cmd_req = 0;
    end
    repeat (40) @(negedge clk);
    summary();
    $finish;
  end
endmodule